// File: doc/BRIEF.md
# Line violation status monitor

This block watches eight independent receive line channels. Each one presents a positive-rail bit and a negative-rail bit per clock. For every channel it looks for three kinds of line fault:

- bipolar violations, where marks fail to alternate;
- line-code violations, where two substitution violations in a row share a polarity;
- excessive zero runs.

A qualifying fault sets that channel's bit in an eight-bit sticky status word. A host reads the word through a one-clock read strobe. The strobe returns the word as it stood before the read and clears it.

Several controls decide which faults count. A line-code mode input selects alternate-mark-inversion or HDB3 rules. A dual-rail-only input restricts reporting to bipolar violations. Per-channel inputs enable zero-run detection and block code-violation reporting. After a channel latches a fault, a short hold window suppresses further faults on that channel. The suppression applies even if the host clears the bit in the meantime.

Top module: `line_viol_monitor`

## Requirements
- R1: After a synchronous active-low reset, every status bit is 0 and `rd_data` is 0.
- R2: A mark (exactly one rail high) with the same polarity as the previous mark on that channel is a bipolar violation, whatever number of zeros lies between the two marks. Counted violations set bit n-1 for channel n, and a channel whose marks alternate sets nothing. In HDB3 mode with `dual_rail_only` low, such a same-polarity pair is counted only as described in R8.
- R3: Both rails high on a channel in one clock is a bipolar violation and always sets that channel's bit.
- R4: A set status bit stays set, with no further line activity, until a read strobe.
- R5: A read strobe sampled at a clock edge loads `rd_data` with the status word from before that edge and clears the word. `rd_data` holds its value until the next strobe.
- R6: When a read strobe and a qualifying fault on a channel arrive in the same clock, that channel's bit ends up set, unless R7 suppresses the fault.
- R7: When a channel latches a fault at edge k, faults on that channel at edges k+1, k+2 and k+3 are not latched, even if a read cleared the bit in that window. A fault at edge k+4 is latched.
- R8: In HDB3 mode (`hdb3_mode` = 1) with `dual_rail_only` low, a same-polarity mark pair is treated as a substitution violation. It sets the bit only when its polarity equals that of the channel's previous substitution violation, which is a code violation.
- R9: A code violation on channel n is not reported while `cv_block[n-1]` is 1.
- R10: With `zero_det_en[n-1]` = 1, each clock in which channel n's current zero run is at least 16 (AMI mode) or at least 4 (HDB3 mode) is a fault. With the enable at 0, zero runs never set the bit.
- R11: With `dual_rail_only` = 1, only bipolar violations set bits: code violations and zero runs are ignored, and same-polarity mark pairs count as bipolar violations even in HDB3 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; line bits sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_pos | input | 8 | Positive-rail bit, one per channel |
| rx_neg | input | 8 | Negative-rail bit, one per channel |
| hdb3_mode | input | 1 | 1 = HDB3 rules, 0 = AMI rules |
| dual_rail_only | input | 1 | 1 = report bipolar violations only |
| zero_det_en | input | 8 | Per-channel zero-run detection enable |
| cv_block | input | 8 | Per-channel code-violation reporting block |
| rd_strobe | input | 1 | One-clock read-and-clear strobe |
| rd_data | output | 8 | Status word captured by the last read |

## Verification
The line symbol sampled at edge k decides the status bit at that same edge. The bit can only be seen through `rd_data`, which updates at the edge that samples a read strobe. A fault is therefore observable one clock later at the earliest, in the cycle of the read strobe. The bench drives line bits and the strobe on the falling edge and reads `rd_data` on the following falling edge. Each read therefore shows the state after exactly one rising edge. The hold-window and zero-run scenarios count edges exactly so that the last suppressed edge and the first accepted edge, and the last short run and the first long run, each fall on a known strobe.

// File: rtl/lv_pkg.sv
// Package: shared types and helpers for the line violation monitor.
// Assumes: one line symbol per channel per clock.
package lv_pkg;

    // Line-code rule selected by the mode input.
    typedef enum logic {
        LINE_AMI  = 1'b0,
        LINE_HDB3 = 1'b1
    } line_code_e;

    // Raw fault flags produced by one channel detector in one clock.
    typedef struct packed {
        logic bpv_both;   // both rails high
        logic bpv_pair;   // same-polarity mark pair
        logic cv;         // pair repeating previous pair polarity
        logic ez;         // zero run at or above the limit
    } lv_events_t;

    // Larger of two zero-run limits, used to size the run counter.
    function automatic int unsigned max_limit(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lv_chan_detect.sv
// Module: per-channel line fault detector.
// Tracks last mark polarity, last pair-violation polarity and zero-run
// length, and flags faults combinationally for the current symbol.
// Assumes: pos/neg are already synchronous to clk.
module lv_chan_detect
    import lv_pkg::*;
#(
    parameter int unsigned AMI_ZEROS  = 16,
    parameter int unsigned HDB3_ZEROS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pos,
    input  logic       neg,
    input  line_code_e code,
    output lv_events_t ev
);

    localparam int unsigned MAXZ = max_limit(AMI_ZEROS, HDB3_ZEROS);
    localparam int unsigned ZW   = $clog2(MAXZ + 1);

    logic          have_mark;
    logic          last_pol;
    logic          have_pair;
    logic          last_pair_pol;
    logic [ZW-1:0] zrun;

    logic          single_mark;
    logic          zero_line;
    logic [ZW:0]   run_now;
    logic [ZW:0]   limit;

    // Classify the present symbol and derive fault flags.
    always_comb begin
        single_mark = pos ^ neg;
        zero_line   = ~pos & ~neg;
        run_now     = {1'b0, zrun} + 1'b1;
        limit       = (code == LINE_HDB3) ? (ZW+1)'(HDB3_ZEROS) : (ZW+1)'(AMI_ZEROS);
        ev.bpv_both = pos & neg;
        ev.bpv_pair = single_mark & have_mark & (last_pol == pos);
        ev.cv       = ev.bpv_pair & have_pair & (last_pair_pol == pos);
        ev.ez       = zero_line & (run_now >= limit);
    end

    // Update polarity trackers on marks and the zero-run counter on every symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_mark     <= 1'b0;
            last_pol      <= 1'b0;
            have_pair     <= 1'b0;
            last_pair_pol <= 1'b0;
            zrun          <= '0;
        end else begin
            if (single_mark) begin
                have_mark <= 1'b1;
                last_pol  <= pos;
            end
            if (ev.bpv_pair) begin
                have_pair     <= 1'b1;
                last_pair_pol <= pos;
            end
            if (zero_line) begin
                if (zrun != ZW'(MAXZ)) zrun <= zrun + 1'b1;
            end else begin
                zrun <= '0;
            end
        end
    end

    // R10: a run that has reached the limit stays flagged while zeros continue.
    p_zero_run_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ev.ez |=> (!(zero_line && $stable(code)) || ev.ez));

endmodule

// File: rtl/lv_event_qualify.sv
// Module: selects which raw faults of one channel may set its status bit.
// Assumes: enables are static or change between symbols.
module lv_event_qualify
    import lv_pkg::*;
(
    input  lv_events_t ev,
    input  line_code_e code,
    input  logic       dual_only,
    input  logic       ez_en,
    input  logic       cv_blk,
    output logic       bpv_hit,
    output logic       hit
);

    logic pair_as_bpv;
    logic cv_ok;
    logic ez_ok;

    // Combine raw faults with the mode and per-channel controls.
    always_comb begin
        pair_as_bpv = ev.bpv_pair & (dual_only | (code == LINE_AMI));
        bpv_hit     = ev.bpv_both | pair_as_bpv;
        cv_ok       = ev.cv & (code == LINE_HDB3) & ~dual_only & ~cv_blk;
        ez_ok       = ev.ez & ez_en & ~dual_only;
        hit         = bpv_hit | cv_ok | ez_ok;
    end

endmodule

// File: rtl/lv_hold_window.sv
// Module: per-channel capture gate; after a fault is accepted, further
// faults are refused for HOLD clocks regardless of host reads.
// Assumes: HOLD >= 1.
module lv_hold_window #(
    parameter int unsigned HOLD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic accept
);

    localparam int unsigned HW = $clog2(HOLD + 1);

    logic [HW-1:0] hold_cnt;

    // Accept only when no window is running.
    always_comb accept = hit & (hold_cnt == '0);

    // Load the window on accept and count it down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)               hold_cnt <= '0;
        else if (accept)          hold_cnt <= HW'(HOLD);
        else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
    end

    // Independent count of clocks since the last accept, for the check below.
    logic [HW-1:0] gap;
    logic          seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (accept) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != HW'(HOLD)) begin
            gap  <= gap + 1'b1;
        end
    end

    // R7: two accepts are at least HOLD+1 edges apart.
    p_hold_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && seen) |-> (gap == HW'(HOLD)));

endmodule

// File: rtl/lv_status_reg.sv
// Module: sticky status word with read-and-clear port.
// Assumes: rd_strobe is one clock wide per read.
module lv_status_reg #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] accept,
    input  logic              rd_strobe,
    output logic [NUM_CH-1:0] status,
    output logic [NUM_CH-1:0] rd_data
);

    // Set bits on accepted faults; a read clears old bits but new ones win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status  <= '0;
            rd_data <= '0;
        end else begin
            status <= (rd_strobe ? '0 : status) | accept;
            if (rd_strobe) rd_data <= status;
        end
    end

    // R4: without a read no set bit is lost.
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> ((status & $past(status)) == $past(status)));

    // R5: a read returns the word from before the clear.
    p_read_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> (rd_data == $past(status)));

    // R6: an accepted fault is visible next clock, read or not.
    p_accept_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|accept) |=> ((status & $past(accept)) == $past(accept)));

endmodule

// File: rtl/line_viol_monitor.sv
// Module: top of the eight-channel line violation status monitor.
// Per channel: detector -> qualifier -> hold window; then shared status reg.
// Assumes: all inputs synchronous to clk.
module line_viol_monitor
    import lv_pkg::*;
#(
    parameter int unsigned NUM_CH     = 8,
    parameter int unsigned AMI_ZEROS  = 16,
    parameter int unsigned HDB3_ZEROS = 4,
    parameter int unsigned HOLD       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] rx_pos,
    input  logic [NUM_CH-1:0] rx_neg,
    input  logic              hdb3_mode,
    input  logic              dual_rail_only,
    input  logic [NUM_CH-1:0] zero_det_en,
    input  logic [NUM_CH-1:0] cv_block,
    input  logic              rd_strobe,
    output logic [NUM_CH-1:0] rd_data
);

    line_code_e        code;
    logic [NUM_CH-1:0] bpv_vec;
    logic [NUM_CH-1:0] hit_vec;
    logic [NUM_CH-1:0] accept_vec;
    logic [NUM_CH-1:0] status;

    // Map the mode pin onto the line-code type.
    always_comb code = line_code_e'(hdb3_mode);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        lv_events_t ev;

        lv_chan_detect #(
            .AMI_ZEROS (AMI_ZEROS),
            .HDB3_ZEROS(HDB3_ZEROS)
        ) i_detect (
            .clk  (clk),
            .rst_n(rst_n),
            .pos  (rx_pos[c]),
            .neg  (rx_neg[c]),
            .code (code),
            .ev   (ev)
        );

        lv_event_qualify i_qualify (
            .ev       (ev),
            .code     (code),
            .dual_only(dual_rail_only),
            .ez_en    (zero_det_en[c]),
            .cv_blk   (cv_block[c]),
            .bpv_hit  (bpv_vec[c]),
            .hit      (hit_vec[c])
        );

        lv_hold_window #(
            .HOLD(HOLD)
        ) i_window (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit_vec[c]),
            .accept(accept_vec[c])
        );
    end

    lv_status_reg #(
        .NUM_CH(NUM_CH)
    ) i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept_vec),
        .rd_strobe(rd_strobe),
        .status   (status),
        .rd_data  (rd_data)
    );

    // R11: in dual-rail-only mode nothing but bipolar violations reaches the gate.
    p_dual_bpv_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dual_rail_only |-> ((hit_vec & ~bpv_vec) == '0));

    // R3: both rails high always produces a fault request on that channel.
    p_both_rails_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_pos & rx_neg) & ~hit_vec) == '0);

endmodule

// File: tb/test_line_viol_monitor.sv
// Directed bench: one task per scenario; inputs driven and outputs read at
// the falling edge, so each cyc() spans exactly one rising edge.
module test_line_viol_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_pos = '0;
    logic [7:0] rx_neg = '0;
    logic       hdb3_mode = 1'b0;
    logic       dual_rail_only = 1'b0;
    logic [7:0] zero_det_en = '0;
    logic [7:0] cv_block = '0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    line_viol_monitor i_line_viol_monitor (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_pos        (rx_pos),
        .rx_neg        (rx_neg),
        .hdb3_mode     (hdb3_mode),
        .dual_rail_only(dual_rail_only),
        .zero_det_en   (zero_det_en),
        .cv_block      (cv_block),
        .rd_strobe     (rd_strobe),
        .rd_data       (rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one symbol set plus strobe, then move to the next falling edge.
    task automatic cyc(input logic [7:0] p, input logic [7:0] n, input logic rd);
        rx_pos = p;
        rx_neg = n;
        rd_strobe = rd;
        @(negedge clk);
    endtask

    task automatic idle(input int cnt);
        for (int i = 0; i < cnt; i++) cyc(8'h00, 8'h00, 1'b0);
    endtask

    task automatic do_reset(input logic hdb3, input logic dual, input logic [7:0] ez, input logic [7:0] cvb);
        hdb3_mode = hdb3;
        dual_rail_only = dual;
        zero_det_en = ez;
        cv_block = cvb;
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        do_reset(1'b0, 1'b0, 8'h00, 8'h00);
        check("R1 rd_data after reset", rd_data, 8'h00);
        cyc(8'h00, 8'h00, 1'b1);
        check("R1 status after reset", rd_data, 8'h00);
    endtask

    task automatic t_bpv_pair;
        // ch3 (bit2): + 0 0 + ; ch6 (bit5) alternates
        do_reset(1'b0, 1'b0, 8'h00, 8'h00);
        cyc(8'h24, 8'h00, 1'b0);
        cyc(8'h00, 8'h20, 1'b0);
        cyc(8'h20, 8'h00, 1'b1);
        check("R2 no fault before pair", rd_data, 8'h00);
        cyc(8'h04, 8'h20, 1'b0);
        cyc(8'h00, 8'h00, 1'b1);
        check("R2 same-polarity pair sets bit2 only", rd_data, 8'h04);
    endtask

    task automatic t_both_rails;
        do_reset(1'b0, 1'b0, 8'h00, 8'h00);
        cyc(8'h01, 8'h01, 1'b0);
        cyc(8'h00, 8'h00, 1'b1);
        check("R3 both rails sets bit0", rd_data, 8'h01);
    endtask

    task automatic t_sticky_read;
        do_reset(1'b0, 1'b0, 8'h00, 8'h00);
        cyc(8'h40, 8'h40, 1'b0);
        idle(10);
        cyc(8'h00, 8'h00, 1'b1);
        check("R4 bit stays set", rd_data, 8'h40);
        idle(3);
        check("R5 rd_data holds", rd_data, 8'h40);
        cyc(8'h00, 8'h00, 1'b1);
        check("R5 read cleared word", rd_data, 8'h00);
    endtask

    task automatic t_read_collide;
        do_reset(1'b0, 1'b0, 8'h00, 8'h00);
        cyc(8'h02, 8'h02, 1'b1);
        check("R6 read returns pre-fault word", rd_data, 8'h00);
        cyc(8'h00, 8'h00, 1'b1);
        check("R6 fault with read stays set", rd_data, 8'h02);
    endtask

    task automatic t_window;
        do_reset(1'b0, 1'b0, 8'h00, 8'h00);
        cyc(8'h10, 8'h10, 1'b0);   // k
        cyc(8'h00, 8'h00, 1'b1);   // k+1
        check("R7 first fault latched", rd_data, 8'h10);
        cyc(8'h00, 8'h00, 1'b0);   // k+2
        cyc(8'h10, 8'h10, 1'b0);   // k+3 suppressed
        cyc(8'h10, 8'h10, 1'b1);   // k+4 accepted
        check("R7 fault at k+3 suppressed after clear", rd_data, 8'h00);
        cyc(8'h00, 8'h00, 1'b0);
        cyc(8'h00, 8'h00, 1'b1);
        check("R7 fault at k+4 latched", rd_data, 8'h10);
    endtask

    task automatic t_code_viol(input logic blk);
        do_reset(1'b1, 1'b0, 8'h00, blk ? 8'h40 : 8'h00);
        cyc(8'h40, 8'h00, 1'b0);
        cyc(8'h40, 8'h00, 1'b0);   // first substitution pair, not reported
        cyc(8'h00, 8'h00, 1'b1);
        check("R8 lone substitution pair ignored", rd_data, 8'h00);
        cyc(8'h00, 8'h40, 1'b0);
        cyc(8'h40, 8'h00, 1'b0);
        cyc(8'h40, 8'h00, 1'b0);   // repeat polarity -> code violation
        cyc(8'h00, 8'h00, 1'b1);
        if (blk) check("R9 blocked code violation", rd_data, 8'h00);
        else     check("R8 code violation sets bit6", rd_data, 8'h40);
    endtask

    task automatic t_zero_run(input logic hdb3, input int lim);
        do_reset(hdb3, 1'b0, 8'h80, 8'h00);
        cyc(8'h80, 8'h00, 1'b0);
        idle(lim - 2);
        cyc(8'h00, 8'h00, 1'b1);   // run = lim-1
        check("R10 run one short", rd_data, 8'h00);
        cyc(8'h00, 8'h00, 1'b0);   // run = lim
        cyc(8'h00, 8'h80, 1'b1);
        check("R10 run at limit sets bit7", rd_data, 8'h80);
    endtask

    task automatic t_zero_disabled;
        do_reset(1'b0, 1'b0, 8'h00, 8'h00);
        idle(20);
        cyc(8'h00, 8'h00, 1'b1);
        check("R10 disabled zero run ignored", rd_data, 8'h00);
    endtask

    task automatic t_dual_only;
        do_reset(1'b1, 1'b1, 8'hFF, 8'h00);
        cyc(8'h08, 8'h00, 1'b0);
        cyc(8'h08, 8'h00, 1'b0);
        cyc(8'h00, 8'h00, 1'b1);
        check("R11 pair counted as bipolar in dual mode", rd_data, 8'h08);
        idle(8);
        cyc(8'h00, 8'h00, 1'b1);
        check("R11 zero runs ignored in dual mode", rd_data, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_bpv_pair();
        t_both_rails();
        t_sticky_read();
        t_read_collide();
        t_window();
        t_code_viol(1'b0);
        t_code_viol(1'b1);
        t_zero_run(1'b0, 16);
        t_zero_run(1'b1, 4);
        t_zero_disabled();
        t_dual_only();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule